// File: doc/BRIEF.md
# Multi-mode ATM cell rate pacer

This block decides, for every physical-layer port of an ATM transmitter, when a cell should be sent. It has three pacing modes, chosen by a two-bit mode select. In the line-paced mode, each port's FIFO-has-room flag drives the send request directly. If no data cell is waiting, the request is marked as an idle or unassigned filler cell, so the line rate is held.

In the two timer-paced modes, each paced port has a down-counting timer. The timer reloads from a per-port rate value and advances only on a shared rate tick, which comes from one selected baud-rate generator. The ordinary timer mode paces only the first few ports and leaves the rest line-paced. The expanded timer mode paces every port and ignores the FIFO flags. Timer-paced ports never produce filler cells. A request stays pending until the transmitter acknowledges it. An expiry that lands on a pending request is recorded in a sticky per-port overrun flag.

Top module: `atm_rate_pacer`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `send_req`, `idle_fill` and `overrun` are all zero. The held mode starts as line-paced (2'b00).
- R2: In line-paced mode (`mode_sel` = 2'b00), `send_req[p]` equals `fifo_room[p]` from the previous clock cycle, for every port.
- R3: In line-paced mode, `idle_fill[p]` equals `fifo_room[p] & ~cell_ready` from the previous cycle.
- R4: In timer mode (`mode_sel` = 2'b01), ports 0 to INT_PORTS-1 are timer-paced. All higher ports behave as in R2 and R3.
- R5: In expanded timer mode (`mode_sel` = 2'b10), every port is timer-paced, and `fifo_room` and `cell_ready` have no effect.
- R6: A timer changes only on cycles with `rate_tick` high. The first tick after a mode entry loads the port's reload value. A tick that finds the count at 1 raises the request and reloads in the same tick. The first request therefore comes on tick reload+1, and later requests follow every reload ticks.
- R7: A timer-paced port never asserts `idle_fill`.
- R8: A timer-paced port whose reload value is zero never raises `send_req`.
- R9: A raised request stays high until `send_ack[p]` clears it. If the timer expires while the request is pending and not acknowledged, the request stays a single request and `overrun[p]` is set and held. If the expiry and the acknowledge fall in the same cycle, the request stays high and no overrun is flagged.
- R10: On the cycle after `mode_sel` differs from the held mode, all requests, fillers and overrun flags read zero, and every timer is back in its unloaded state.
- R11: `mode_sel` = 2'b11 is reserved. No port raises `send_req` or `idle_fill` in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Pacing mode: 00 line, 01 timer, 10 expanded timer, 11 reserved |
| rate_tick | input | 1 | One-cycle pulse from the selected baud-rate generator |
| cell_ready | input | 1 | A data cell is available to send |
| fifo_room | input | NUM_PORTS | Per-port PHY FIFO can accept a cell |
| send_ack | input | NUM_PORTS | Transmitter has taken the pending request |
| reload_flat | input | NUM_PORTS*TMR_W | Per-port reload values, port p at bits p*TMR_W and up |
| send_req | output | NUM_PORTS | Per-port send request |
| idle_fill | output | NUM_PORTS | Request is an idle/unassigned filler cell |
| overrun | output | NUM_PORTS | Sticky: timer expired on a still-pending request |

## Verification
The assertions assume that `rst` is high from time zero for at least one cycle. They also assume that `mode_sel` is a plain level that the surrounding logic may change at any clock edge. The stimulus drives every input only at falling edges. It holds `mode_sel` steady across each pacing phase and changes it only between phases. Acknowledges are one-cycle pulses aimed at pending ports. The stimulus also covers an acknowledge that lands on the tick of a fresh expiry.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  typedef enum logic [1:0] {
    PM_LINE  = 2'b00,
    PM_TMR   = 2'b01,
    PM_XTMR  = 2'b10,
    PM_RSVD  = 2'b11
  } pace_mode_t;
endpackage

// File: rtl/pace_mode_ctrl.sv
module pace_mode_ctrl
  import pacer_pkg::*;
#(
  parameter int NUM_PORTS = 31,
  parameter int INT_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           mode_sel,
  output pace_mode_t           mode_q,
  output logic                 mode_chg,
  output logic [NUM_PORTS-1:0] tmr_en,
  output logic [NUM_PORTS-1:0] line_en
);
  always_ff @(posedge clk) begin
    if (rst) mode_q <= PM_LINE;
    else     mode_q <= pace_mode_t'(mode_sel);
  end

  assign mode_chg = (mode_sel != mode_q);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_mask
    localparam bit LOW_PORT = (p < INT_PORTS);
    assign tmr_en[p]  = (mode_q == PM_XTMR) || ((mode_q == PM_TMR) && LOW_PORT);
    assign line_en[p] = (mode_q == PM_LINE) || ((mode_q == PM_TMR) && !LOW_PORT);
  end
endmodule

// File: rtl/port_rate_timer.sv
module port_rate_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             tick,
  input  logic [TMR_W-1:0] reload,
  input  logic             ack,
  output logic             req,
  output logic             ovr
);
  localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

  logic [TMR_W-1:0] cnt;
  logic             live;
  logic             expire;

  assign live   = (reload != '0);
  assign expire = tick && live && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst || clr || !en) begin
      cnt <= '0;
      req <= 1'b0;
      ovr <= 1'b0;
    end else begin
      if (tick) begin
        if (!live)                        cnt <= '0;
        else if (cnt == '0 || cnt == ONE) cnt <= reload;
        else                              cnt <= cnt - ONE;
      end
      if (expire) begin
        req <= 1'b1;
        if (req && !ack) ovr <= 1'b1;
      end else if (ack) begin
        req <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/port_line_pacer.sv
module port_line_pacer (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic room,
  input  logic cell_ready,
  output logic req,
  output logic fill
);
  always_ff @(posedge clk) begin
    if (rst || clr || !en) begin
      req  <= 1'b0;
      fill <= 1'b0;
    end else begin
      req  <= room;
      fill <= room && !cell_ready;
    end
  end
endmodule

// File: rtl/atm_rate_pacer.sv
module atm_rate_pacer
  import pacer_pkg::*;
#(
  parameter int NUM_PORTS = 31,
  parameter int INT_PORTS = 4,
  parameter int TMR_W     = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [1:0]                 mode_sel,
  input  logic                       rate_tick,
  input  logic                       cell_ready,
  input  logic [NUM_PORTS-1:0]       fifo_room,
  input  logic [NUM_PORTS-1:0]       send_ack,
  input  logic [NUM_PORTS*TMR_W-1:0] reload_flat,
  output logic [NUM_PORTS-1:0]       send_req,
  output logic [NUM_PORTS-1:0]       idle_fill,
  output logic [NUM_PORTS-1:0]       overrun
);
  pace_mode_t           mode_q;
  logic                 mode_chg;
  logic [NUM_PORTS-1:0] tmr_en, line_en;
  logic [NUM_PORTS-1:0] tmr_req, line_req, line_fill;

  pace_mode_ctrl #(.NUM_PORTS(NUM_PORTS), .INT_PORTS(INT_PORTS)) u_mode (
    .clk(clk), .rst(rst), .mode_sel(mode_sel),
    .mode_q(mode_q), .mode_chg(mode_chg),
    .tmr_en(tmr_en), .line_en(line_en)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    port_rate_timer #(.TMR_W(TMR_W)) u_tmr (
      .clk(clk), .rst(rst), .clr(mode_chg), .en(tmr_en[p]),
      .tick(rate_tick), .reload(reload_flat[p*TMR_W +: TMR_W]),
      .ack(send_ack[p]), .req(tmr_req[p]), .ovr(overrun[p])
    );
    port_line_pacer u_line (
      .clk(clk), .rst(rst), .clr(mode_chg), .en(line_en[p]),
      .room(fifo_room[p]), .cell_ready(cell_ready),
      .req(line_req[p]), .fill(line_fill[p])
    );
  end

  assign send_req  = tmr_req | line_req;
  assign idle_fill = line_fill;
endmodule

// File: rtl/atm_rate_pacer_chk.sv
module atm_rate_pacer_chk
  import pacer_pkg::*;
#(
  parameter int NUM_PORTS = 31,
  parameter int INT_PORTS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [1:0]           mode_sel,
  input pace_mode_t           mode_q,
  input logic [NUM_PORTS-1:0] fifo_room,
  input logic [NUM_PORTS-1:0] send_req,
  input logic [NUM_PORTS-1:0] idle_fill,
  input logic [NUM_PORTS-1:0] overrun
);
  // R2
  line_follows_room_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == PM_LINE && mode_q == PM_LINE) |=> (send_req == $past(fifo_room)));

  // R7
  xtmr_no_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_XTMR) |-> (idle_fill == '0));

  // R7
  tmr_low_no_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_TMR) |-> (idle_fill[INT_PORTS-1:0] == '0));

  // R10
  mode_switch_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel != mode_q) |=> (send_req == '0 && overrun == '0 && idle_fill == '0));

  // R9
  overrun_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
    ((overrun & ~$past(overrun) & ~$past(send_req)) == '0));

  // R3
  fill_implies_req_chk: assert property (@(posedge clk) disable iff (rst)
    ((idle_fill & ~send_req) == '0));

  // R11
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_RSVD) |-> (send_req == '0));
endmodule

bind atm_rate_pacer atm_rate_pacer_chk #(.NUM_PORTS(NUM_PORTS), .INT_PORTS(INT_PORTS)) u_chk (
  .clk(clk), .rst(rst), .mode_sel(mode_sel), .mode_q(mode_q),
  .fifo_room(fifo_room), .send_req(send_req), .idle_fill(idle_fill), .overrun(overrun)
);

// File: tb/tb_atm_rate_pacer.sv
module tb_atm_rate_pacer;
  localparam int N = 8;
  localparam int IP = 4;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   mode_sel = 2'b00;
  logic         rate_tick = 1'b0;
  logic         cell_ready = 1'b0;
  logic [N-1:0] fifo_room = '0;
  logic [N-1:0] send_ack = '0;
  logic [N*W-1:0] reload_flat = '0;
  logic [N-1:0] send_req, idle_fill, overrun;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  atm_rate_pacer #(.NUM_PORTS(N), .INT_PORTS(IP), .TMR_W(W)) dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .rate_tick(rate_tick),
    .cell_ready(cell_ready), .fifo_room(fifo_room), .send_ack(send_ack),
    .reload_flat(reload_flat), .send_req(send_req), .idle_fill(idle_fill),
    .overrun(overrun)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic tick(input logic [N-1:0] ack);
    rate_tick = 1'b1;
    send_ack  = ack;
    step();
    rate_tick = 1'b0;
    send_ack  = '0;
  endtask

  // line-paced vectors: room, cell_ready, expected req, expected fill
  localparam int NV = 5;
  localparam logic [N-1:0] V_ROOM [NV] = '{8'hFF, 8'h00, 8'hA5, 8'h3C, 8'h81};
  localparam logic         V_RDY  [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [N-1:0] V_REQ  [NV] = '{8'hFF, 8'h00, 8'hA5, 8'h3C, 8'h81};
  localparam logic [N-1:0] V_FIL  [NV] = '{8'hFF, 8'h00, 8'h00, 8'h3C, 8'h00};

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    fifo_room = '1;
    step(); step();
    chk("R1 req in reset", send_req, '0);
    chk("R1 fill in reset", idle_fill, '0);
    rst = 1'b0;
    step();
    // fifo_room was high at the edge, so line mode now requests
    chk("R1 ovr after reset", overrun, '0);

    for (int i = 0; i < NV; i++) begin
      fifo_room  = V_ROOM[i];
      cell_ready = V_RDY[i];
      send_ack   = ~V_ROOM[i];
      step();
      chk($sformatf("R2 vec%0d req", i), send_req, V_REQ[i]);
      chk($sformatf("R3 vec%0d fill", i), idle_fill, V_FIL[i]);
    end
    send_ack = '0;

    // timer mode: p0=3, p1=1, p2=0, p3=2
    reload_flat = '0;
    reload_flat[0*W +: W] = 8'd3;
    reload_flat[1*W +: W] = 8'd1;
    reload_flat[2*W +: W] = 8'd0;
    reload_flat[3*W +: W] = 8'd2;
    fifo_room  = '1;
    cell_ready = 1'b0;
    mode_sel   = 2'b01;
    step();
    chk("R10 req cleared on switch", send_req, '0);
    step();
    chk("R4 high ports line-paced", send_req, 8'hF0);
    chk("R7 low ports no fill", idle_fill, 8'hF0);
    step(); step();
    chk("R6 no advance without tick", send_req, 8'hF0);
    tick('0);
    chk("R6 first tick only loads", send_req, 8'hF0);
    tick('0);
    chk("R6 p1 first request", send_req, 8'hF2);
    send_ack = 4'b0010;
    step();
    send_ack = '0;
    chk("R9 ack clears", send_req, 8'hF0);
    tick('0);
    chk("R6 p1 and p3 fire", send_req, 8'hFA);
    tick('0);
    chk("R6 p0 fires tick4", send_req, 8'hFB);
    chk("R9 overrun on pending p1", overrun, 8'h02);
    chk("R8 zero reload silent", {7'd0, send_req[2]}, '0);
    tick(8'h0B);
    chk("R9 ack with expiry keeps req", send_req, 8'hFA);
    chk("R9 no overrun on p3", overrun, 8'h02);

    // expanded mode: only p7 live, reload 2
    reload_flat = '0;
    reload_flat[7*W +: W] = 8'd2;
    mode_sel = 2'b10;
    step();
    chk("R10 req cleared", send_req, '0);
    chk("R10 ovr cleared", overrun, '0);
    cell_ready = 1'b0;
    fifo_room = '1;
    tick('0);
    tick('0);
    chk("R5 room ignored", send_req, '0);
    chk("R7 no fill expanded", idle_fill, '0);
    tick('0);
    chk("R5 p7 fires", send_req, 8'h80);

    mode_sel = 2'b11;
    step(); step();
    tick('0);
    chk("R11 reserved req", send_req, '0);
    chk("R11 reserved fill", idle_fill, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule